// File: doc/BRIEF.md
# Interrupt Line Capture and Register Front End

This block sits between a set of raw interrupt request wires and a separate priority arbiter. Each raw line passes through a two-flop synchroniser and is then turned into a pending bit. A per-line sense setting decides how that happens. An edge-type line latches a request on each low-to-high change and holds it until software takes it. A level-type line tracks its input: it is pending while the input is high and drops when the input falls.

Software reaches the block through a simple word-wide register port. Through that port it can read and clear pending bits, program the mask, and set each line's priority, sense and IRQ/FIQ path. It can also inject a request from software and ask the arbiter to start a fresh arbitration round. The arbiter receives the pending, mask, path-select and priority vectors on dedicated outputs and returns the winning line index for each path. When software reads a winner code, that read serves as the acknowledge: an edge-type winner has its pending bit dropped as part of the same access.

Top module: `irq_capture_regs`

## Requirements
- R1: After reset the mask reads all ones, every pending, sense and path-select bit is zero, every priority is zero and both arbitration strobes are low.
- R2: A change on a raw line reaches the pending logic through two flip-flops, so an edge-type line (sense bit 0) shows its pending bit at the third rising clock edge after the input rose; a line held high does not set it again.
- R3: An edge-type pending bit stays set after its input falls, until an acknowledge or a software clear removes it.
- R4: A level-type line (sense bit 1) is pending whenever its synchronised input is high, and its pending bit clears when that input falls.
- R5: A write to offset 0x00 ANDs the data into the pending bits, except that level-type lines whose synchronised input is high keep their bit; a read of 0x00 returns the pending bits.
- R6: A read of 0x10 returns the IRQ winner index from the arbiter and a read of 0x14 the FIQ winner index, in bits [4:0]. The same access clears that line's pending bit if the line is edge-type and leaves it alone if the line is level-type.
- R7: The word at 0x1C + 4·n configures line n: priority in bits [6:2], sense in bit 1, path select in bit 0 (1 = FIQ). It reads back in that layout, and the fields appear on prio_o and fiq_sel_o.
- R8: Offset 0x04 holds the mask. It is written whole, reads back, and drives mask_o.
- R9: Writing offset 0x18 with bit 0 set pulses new_irq_agr_o, and with bit 1 set pulses new_fiq_agr_o, for one cycle after the write. The register reads as zero.
- R10: A write to offset 0x9C acts only on the lowest set bit n of the data. It sets pending bit n unless line n is edge-type with its synchronised input already high. The register reads as zero.
- R11: Every read returns its data with rsp_valid_o high one cycle after the request. An access to an unmapped offset, or to an address with bits [1:0] not zero, changes no state and reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_lines_i | input | NUM_LINES | Raw interrupt request lines, active high |
| req_valid_i | input | 1 | Register access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte offset of the access |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata_o | output | 32 | Read data |
| irq_winner_i | input | $clog2(NUM_LINES) | Winning line index on the IRQ path from the arbiter |
| fiq_winner_i | input | $clog2(NUM_LINES) | Winning line index on the FIQ path from the arbiter |
| pending_o | output | NUM_LINES | Pending bits to the arbiter |
| mask_o | output | NUM_LINES | Mask bits to the arbiter (1 = masked) |
| fiq_sel_o | output | NUM_LINES | Path select per line (1 = FIQ) |
| prio_o | output | NUM_LINES*PRIO_W | Priority of line n in bits [n*PRIO_W +: PRIO_W] |
| new_irq_agr_o | output | 1 | One-cycle request for a new IRQ arbitration |
| new_fiq_agr_o | output | 1 | One-cycle request for a new FIQ arbitration |

## Verification
Every result has a fixed latency. A raw line change shows on pending_o three rising edges later, because of the two synchroniser flops plus the pending register. Register writes, acknowledges, software triggers and arbitration strobes take effect one edge after the request, and read data arrives one edge after a read. The bench drives on falling edges and samples on the next falling edge. It checks pending one and two edges too early for the synchroniser case. Its reference model steps once per rising edge with the same pipeline depths, so the comparisons on each clock line up with those latencies.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int WORD_W       = 32;
    localparam int OFS_PEND     = 'h00;
    localparam int OFS_MASK     = 'h04;
    localparam int OFS_IRQ_CODE = 'h10;
    localparam int OFS_FIQ_CODE = 'h14;
    localparam int OFS_CTRL     = 'h18;
    localparam int OFS_CFG_BASE = 'h1C;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_PEND,
        ACC_MASK,
        ACC_IRQ_CODE,
        ACC_FIQ_CODE,
        ACC_CTRL,
        ACC_CFG,
        ACC_TRIG
    } acc_kind_e;

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] dout_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout_o = chain_q[STAGES-1];

endmodule

// File: rtl/irqc_decode.sv
module irqc_decode #(
    parameter  int ADDR_W    = 8,
    parameter  int NUM_LINES = 32,
    localparam int IDX_W     = $clog2(NUM_LINES)
) (
    input  logic [ADDR_W-1:0]     addr_i,
    output irqc_pkg::acc_kind_e   kind_o,
    output logic [IDX_W-1:0]      idx_o
);
    import irqc_pkg::*;

    localparam int TRIG_OFS = OFS_CFG_BASE + 4 * NUM_LINES;

    int unsigned ofs;

    always_comb begin
        ofs    = 32'(addr_i);
        kind_o = ACC_NONE;
        idx_o  = '0;
        if (addr_i[1:0] != 2'b00) begin
            kind_o = ACC_NONE;
        end else if (ofs == OFS_PEND) begin
            kind_o = ACC_PEND;
        end else if (ofs == OFS_MASK) begin
            kind_o = ACC_MASK;
        end else if (ofs == OFS_IRQ_CODE) begin
            kind_o = ACC_IRQ_CODE;
        end else if (ofs == OFS_FIQ_CODE) begin
            kind_o = ACC_FIQ_CODE;
        end else if (ofs == OFS_CTRL) begin
            kind_o = ACC_CTRL;
        end else if (ofs >= OFS_CFG_BASE && ofs < TRIG_OFS) begin
            kind_o = ACC_CFG;
            idx_o  = IDX_W'((ofs - OFS_CFG_BASE) >> 2);
        end else if (ofs == TRIG_OFS) begin
            kind_o = ACC_TRIG;
        end
    end

endmodule

// File: rtl/irqc_capture.sv
module irqc_capture #(
    parameter int NUM_LINES = 32
) (
    input  logic [NUM_LINES-1:0] sync_i,
    input  logic [NUM_LINES-1:0] hist_i,
    input  logic [NUM_LINES-1:0] sense_i,
    input  logic [NUM_LINES-1:0] pend_i,
    input  logic [NUM_LINES-1:0] keep_i,
    input  logic [NUM_LINES-1:0] ack_i,
    input  logic [NUM_LINES-1:0] trig_i,
    output logic [NUM_LINES-1:0] pend_d_o
);

    // Software clears and acknowledges act first; hardware events win over them.
    logic [NUM_LINES-1:0] base;
    assign base = pend_i & keep_i & ~(ack_i & ~sense_i);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        assign pend_d_o[g] = sense_i[g]
            ? (sync_i[g] | (~hist_i[g] & (base[g] | trig_i[g])))
            : (base[g] | (sync_i[g] & ~hist_i[g]) | (trig_i[g] & ~sync_i[g]));
    end

endmodule

// File: rtl/irqc_lowest.sv
module irqc_lowest #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] vec_i,
    output logic [WIDTH-1:0] onehot_o
);

    assign onehot_o = vec_i & (~vec_i + WIDTH'(1));

endmodule

// File: rtl/irq_capture_regs.sv
module irq_capture_regs #(
    parameter  int NUM_LINES   = 32,
    parameter  int PRIO_W      = 5,
    parameter  int ADDR_W      = 8,
    parameter  int SYNC_STAGES = 2,
    localparam int IDX_W       = $clog2(NUM_LINES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_LINES-1:0]        irq_lines_i,
    input  logic                        req_valid_i,
    input  logic                        req_write_i,
    input  logic [ADDR_W-1:0]           req_addr_i,
    input  logic [31:0]                 req_wdata_i,
    output logic                        rsp_valid_o,
    output logic [31:0]                 rsp_rdata_o,
    input  logic [IDX_W-1:0]            irq_winner_i,
    input  logic [IDX_W-1:0]            fiq_winner_i,
    output logic [NUM_LINES-1:0]        pending_o,
    output logic [NUM_LINES-1:0]        mask_o,
    output logic [NUM_LINES-1:0]        fiq_sel_o,
    output logic [NUM_LINES*PRIO_W-1:0] prio_o,
    output logic                        new_irq_agr_o,
    output logic                        new_fiq_agr_o
);
    import irqc_pkg::*;

    typedef struct packed {
        logic [NUM_LINES-1:0]             pend;
        logic [NUM_LINES-1:0]             mask;
        logic [NUM_LINES-1:0]             sense;
        logic [NUM_LINES-1:0]             sel;
        logic [NUM_LINES-1:0]             hist;
        logic [NUM_LINES-1:0][PRIO_W-1:0] prio;
        logic                             rvalid;
        logic [WORD_W-1:0]                rdata;
        logic                             agr_irq;
        logic                             agr_fiq;
    } state_t;

    state_t st_d, st_q;

    acc_kind_e            kind;
    logic [IDX_W-1:0]     cfg_idx;
    logic [NUM_LINES-1:0] sync_lines;
    logic [NUM_LINES-1:0] trig_raw;
    logic [NUM_LINES-1:0] trig_vec;
    logic [NUM_LINES-1:0] keep_vec;
    logic [NUM_LINES-1:0] ack_vec;
    logic [NUM_LINES-1:0] pend_next;
    logic                 wr_acc;
    logic                 rd_acc;

    assign wr_acc = req_valid_i && req_write_i;
    assign rd_acc = req_valid_i && !req_write_i;

    irqc_sync #(
        .WIDTH  (NUM_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_i  (irq_lines_i),
        .dout_o (sync_lines)
    );

    irqc_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_LINES (NUM_LINES)
    ) u_decode (
        .addr_i (req_addr_i),
        .kind_o (kind),
        .idx_o  (cfg_idx)
    );

    irqc_lowest #(
        .WIDTH (NUM_LINES)
    ) u_lowest (
        .vec_i    (req_wdata_i[NUM_LINES-1:0]),
        .onehot_o (trig_raw)
    );

    always_comb begin
        keep_vec = '1;
        ack_vec  = '0;
        trig_vec = '0;
        if (wr_acc && kind == ACC_PEND) begin
            keep_vec = req_wdata_i[NUM_LINES-1:0] | (st_q.sense & sync_lines);
        end
        if (wr_acc && kind == ACC_TRIG) begin
            trig_vec = trig_raw;
        end
        if (rd_acc && kind == ACC_IRQ_CODE) begin
            ack_vec = NUM_LINES'(1) << irq_winner_i;
        end else if (rd_acc && kind == ACC_FIQ_CODE) begin
            ack_vec = NUM_LINES'(1) << fiq_winner_i;
        end
    end

    irqc_capture #(
        .NUM_LINES (NUM_LINES)
    ) u_capture (
        .sync_i   (sync_lines),
        .hist_i   (st_q.hist),
        .sense_i  (st_q.sense),
        .pend_i   (st_q.pend),
        .keep_i   (keep_vec),
        .ack_i    (ack_vec),
        .trig_i   (trig_vec),
        .pend_d_o (pend_next)
    );

    always_comb begin
        st_d         = st_q;
        st_d.hist    = sync_lines;
        st_d.pend    = pend_next;
        st_d.rvalid  = rd_acc;
        st_d.rdata   = '0;
        st_d.agr_irq = 1'b0;
        st_d.agr_fiq = 1'b0;

        if (rd_acc) begin
            case (kind)
                ACC_PEND:     st_d.rdata = WORD_W'(st_q.pend);
                ACC_MASK:     st_d.rdata = WORD_W'(st_q.mask);
                ACC_IRQ_CODE: st_d.rdata = WORD_W'(irq_winner_i);
                ACC_FIQ_CODE: st_d.rdata = WORD_W'(fiq_winner_i);
                ACC_CFG:      st_d.rdata = (WORD_W'(st_q.prio[cfg_idx]) << 2)
                                         | (WORD_W'(st_q.sense[cfg_idx]) << 1)
                                         | WORD_W'(st_q.sel[cfg_idx]);
                default:      st_d.rdata = '0;
            endcase
        end

        if (wr_acc) begin
            case (kind)
                ACC_MASK: st_d.mask = req_wdata_i[NUM_LINES-1:0];
                ACC_CTRL: begin
                    st_d.agr_irq = req_wdata_i[0];
                    st_d.agr_fiq = req_wdata_i[1];
                end
                ACC_CFG: begin
                    st_d.prio[cfg_idx]  = req_wdata_i[2 +: PRIO_W];
                    st_d.sense[cfg_idx] = req_wdata_i[1];
                    st_d.sel[cfg_idx]   = req_wdata_i[0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pending_o     = st_q.pend;
    assign mask_o        = st_q.mask;
    assign fiq_sel_o     = st_q.sel;
    assign prio_o        = st_q.prio;
    assign rsp_valid_o   = st_q.rvalid;
    assign rsp_rdata_o   = st_q.rdata;
    assign new_irq_agr_o = st_q.agr_irq;
    assign new_fiq_agr_o = st_q.agr_fiq;

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int NUM_LINES = 32,
    parameter int ADDR_W    = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid_i,
    input logic                 req_write_i,
    input logic [ADDR_W-1:0]    req_addr_i,
    input logic [31:0]          req_wdata_i,
    input logic                 rsp_valid_o,
    input logic [31:0]          rsp_rdata_o,
    input logic [NUM_LINES-1:0] mask_o,
    input logic                 new_irq_agr_o,
    input logic                 new_fiq_agr_o
);
    localparam int TRIG_OFS = irqc_pkg::OFS_CFG_BASE + 4 * NUM_LINES;

    logic is_rd, is_wr;
    int   ofs;
    assign is_rd = req_valid_i && !req_write_i;
    assign is_wr = req_valid_i && req_write_i;
    assign ofs   = 32'(req_addr_i);

    assert_reset_mask_R1: assert property (@(posedge clk)
        !rst_n |=> (mask_o == '1));

    assert_mask_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_wr && ofs == irqc_pkg::OFS_MASK) |=> (mask_o == $past(req_wdata_i[NUM_LINES-1:0])));

    assert_irq_strobe_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
        new_irq_agr_o |-> $past(is_wr && ofs == irqc_pkg::OFS_CTRL && req_wdata_i[0]));

    assert_fiq_strobe_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
        new_fiq_agr_o |-> $past(is_wr && ofs == irqc_pkg::OFS_CTRL && req_wdata_i[1]));

    assert_ctrl_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd && ofs == irqc_pkg::OFS_CTRL) |=> (rsp_rdata_o == 32'd0));

    assert_trig_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd && ofs == TRIG_OFS) |=> (rsp_rdata_o == 32'd0));

    assert_rsp_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |=> rsp_valid_o);

    assert_no_spurious_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !is_rd |=> !rsp_valid_o);

    assert_misaligned_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd && req_addr_i[1:0] != 2'b00) |=> (rsp_rdata_o == 32'd0));

endmodule

bind irq_capture_regs irqc_checker #(
    .NUM_LINES (NUM_LINES),
    .ADDR_W    (ADDR_W)
) u_irqc_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid_i   (req_valid_i),
    .req_write_i   (req_write_i),
    .req_addr_i    (req_addr_i),
    .req_wdata_i   (req_wdata_i),
    .rsp_valid_o   (rsp_valid_o),
    .rsp_rdata_o   (rsp_rdata_o),
    .mask_o        (mask_o),
    .new_irq_agr_o (new_irq_agr_o),
    .new_fiq_agr_o (new_fiq_agr_o)
);

// File: tb/irq_capture_regs_tb_top.sv
`timescale 1ns/1ps
module irq_capture_regs_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [31:0]  irq_lines = '0;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [7:0]   req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic [4:0]   irq_winner = '0;
    logic [4:0]   fiq_winner = '0;
    logic         rsp_valid;
    logic [31:0]  rsp_rdata;
    logic [31:0]  pending, mask, fiq_sel;
    logic [159:0] prio;
    logic         agr_irq, agr_fiq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    irq_capture_regs dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .irq_lines_i   (irq_lines),
        .req_valid_i   (req_valid),
        .req_write_i   (req_write),
        .req_addr_i    (req_addr),
        .req_wdata_i   (req_wdata),
        .rsp_valid_o   (rsp_valid),
        .rsp_rdata_o   (rsp_rdata),
        .irq_winner_i  (irq_winner),
        .fiq_winner_i  (fiq_winner),
        .pending_o     (pending),
        .mask_o        (mask),
        .fiq_sel_o     (fiq_sel),
        .prio_o        (prio),
        .new_irq_agr_o (agr_irq),
        .new_fiq_agr_o (agr_fiq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Behavioural reference model, one step per rising edge.
    logic [31:0] m_s1, m_s2, m_hist, m_pend, m_mask, m_sense, m_sel, m_rd;
    logic [4:0]  m_prio [32];
    logic        m_rv, m_ai, m_af;

    always @(posedge clk) begin
        logic [31:0] p;
        int a;
        int low;
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_hist = '0; m_pend = '0; m_mask = '1;
            m_sense = '0; m_sel = '0; m_rd = '0; m_rv = 0; m_ai = 0; m_af = 0;
            for (int i = 0; i < 32; i++) m_prio[i] = '0;
        end else begin
            a = (req_addr[1:0] != 2'b00) ? -1 : int'(req_addr);
            p = m_pend;
            if (req_valid && req_write && a == 0)
                for (int i = 0; i < 32; i++)
                    if (!req_wdata[i] && !(m_sense[i] && m_s2[i])) p[i] = 1'b0;
            if (req_valid && !req_write && a == 16 && !m_sense[irq_winner]) p[irq_winner] = 1'b0;
            if (req_valid && !req_write && a == 20 && !m_sense[fiq_winner]) p[fiq_winner] = 1'b0;
            if (req_valid && req_write && a == 156) begin
                low = -1;
                for (int i = 31; i >= 0; i--) if (req_wdata[i]) low = i;
                if (low >= 0 && (m_sense[low] || !m_s2[low])) p[low] = 1'b1;
            end
            for (int i = 0; i < 32; i++) begin
                if (m_sense[i]) begin
                    if (m_s2[i]) p[i] = 1'b1;
                    else if (m_hist[i]) p[i] = 1'b0;
                end else if (m_s2[i] && !m_hist[i]) p[i] = 1'b1;
            end
            m_rv = req_valid && !req_write;
            m_rd = '0;
            if (m_rv) begin
                if (a == 0) m_rd = m_pend;
                else if (a == 4) m_rd = m_mask;
                else if (a == 16) m_rd = 32'(irq_winner);
                else if (a == 20) m_rd = 32'(fiq_winner);
                else if (a >= 28 && a < 156)
                    m_rd = {25'd0, m_prio[(a-28)/4], m_sense[(a-28)/4], m_sel[(a-28)/4]};
            end
            m_ai = req_valid && req_write && a == 24 && req_wdata[0];
            m_af = req_valid && req_write && a == 24 && req_wdata[1];
            if (req_valid && req_write && a == 4) m_mask = req_wdata;
            if (req_valid && req_write && a >= 28 && a < 156) begin
                m_prio[(a-28)/4]  = req_wdata[6:2];
                m_sense[(a-28)/4] = req_wdata[1];
                m_sel[(a-28)/4]   = req_wdata[0];
            end
            m_pend = p;
            m_hist = m_s2;
            m_s2   = m_s1;
            m_s1   = irq_lines;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("pending model R2 R3 R4 R5 R6 R10", pending, m_pend);
            chk("mask model R8", mask, m_mask);
            chk("select model R7", fiq_sel, m_sel);
            for (int i = 0; i < 32; i++) chk("priority model R7", 32'(prio[i*5 +: 5]), 32'(m_prio[i]));
            chk("strobes model R9", {30'd0, agr_fiq, agr_irq}, {30'd0, m_af, m_ai});
            chk("rsp valid model R11", 32'(rsp_valid), 32'(m_rv));
            if (rsp_valid) chk("rsp data model R11", rsp_rdata, m_rd);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        req_valid = 1; req_write = 0; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        d = rsp_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 mask", mask, 32'hFFFF_FFFF);
        chk("R1 pending", pending, 32'h0);
        chk("R1 select", fiq_sel, 32'h0);
        chk("R1 prio", prio[31:0], 32'h0);
        chk("R1 strobes", {30'd0, agr_fiq, agr_irq}, 32'h0);
        rd(8'h1C + 8'd20, d); chk("R1 cfg line5", d, 32'h0);

        // R8 mask
        wr(8'h04, 32'h0);
        chk("R8 mask out", mask, 32'h0);
        rd(8'h04, d); chk("R8 mask read", d, 32'h0);

        // R2 edge capture timing
        irq_lines[3] = 1;
        @(negedge clk); chk("R2 one edge", 32'(pending[3]), 0);
        @(negedge clk); chk("R2 two edges", 32'(pending[3]), 0);
        @(negedge clk); chk("R2 third edge", 32'(pending[3]), 1);
        idle(4);
        irq_lines[3] = 0;
        idle(5);
        chk("R3 edge holds", 32'(pending[3]), 1);

        // R6 acknowledge of an edge line
        irq_winner = 5'd3;
        rd(8'h10, d);
        chk("R6 irq code", d, 32'd3);
        chk("R6 edge cleared", 32'(pending[3]), 0);

        // R7 configuration of a level line
        wr(8'h1C + 8'd28, 32'h26);
        rd(8'h1C + 8'd28, d); chk("R7 cfg readback", d, 32'h26);
        chk("R7 prio out", 32'(prio[35 +: 5]), 32'd9);
        irq_lines[7] = 1;
        idle(3);
        chk("R4 level set", 32'(pending[7]), 1);
        wr(8'h00, 32'h0);
        chk("R5 level kept", 32'(pending[7]), 1);
        fiq_winner = 5'd7;
        rd(8'h14, d);
        chk("R6 fiq code", d, 32'd7);
        chk("R6 level not acked", 32'(pending[7]), 1);
        irq_lines[7] = 0;
        idle(2); chk("R4 level still", 32'(pending[7]), 1);
        @(negedge clk); chk("R4 level clear", 32'(pending[7]), 0);

        // R5 clear of an edge line with its input high
        irq_lines[3] = 1;
        idle(3);
        chk("R5 edge set", 32'(pending[3]), 1);
        wr(8'h00, ~32'h8);
        chk("R5 edge cleared", 32'(pending[3]), 0);
        rd(8'h00, d); chk("R5 pending read", d, 32'h0);

        // R7 path select
        wr(8'h1C + 8'd12, 32'h1);
        chk("R7 select out", fiq_sel, 32'h8);

        // R9 control strobes
        wr(8'h18, 32'h1);
        chk("R9 irq strobe", {30'd0, agr_fiq, agr_irq}, 32'h1);
        @(negedge clk);
        chk("R9 strobe drops", {30'd0, agr_fiq, agr_irq}, 32'h0);
        wr(8'h18, 32'h3);
        chk("R9 both strobes", {30'd0, agr_fiq, agr_irq}, 32'h3);
        rd(8'h18, d); chk("R9 ctrl reads zero", d, 32'h0);

        // R10 software trigger
        wr(8'h9C, 32'h0000_0A00);
        chk("R10 lowest only", pending & 32'h0000_0A00, 32'h0000_0200);
        rd(8'h9C, d); chk("R10 trig reads zero", d, 32'h0);
        wr(8'h9C, 32'h8);
        chk("R10 edge high no set", 32'(pending[3]), 0);

        // R11 unmapped and misaligned
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h05, 32'hFFFF_FFFF);
        chk("R11 mask unchanged", mask, 32'h0);
        rd(8'h08, d); chk("R11 unmapped read", d, 32'h0);
        rd(8'hA0, d); chk("R11 beyond map", d, 32'h0);
        rd(8'h01, d); chk("R11 misaligned read", d, 32'h0);
        chk("R11 rsp valid", 32'(rsp_valid), 32'h1);

        irq_lines = 32'h00F0_0F00;
        idle(6);
        irq_lines = 32'h0;
        idle(6);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule